// File: doc/BRIEF.md
# Watchdog and Periodic Interrupt Timer

This block runs from the bus clock and derives two services from one free-running prescaler. It produces a periodic tick for a real-time interrupt, and it counts those ticks to supervise software. Software picks one of four tick rates, and each rate step doubles the period. If software enables supervision and then stops servicing it for too long, the block raises a system reset request. The request is held for a fixed number of cycles, and then supervision returns to its disabled state.

Software talks to the block through two write strobes. The control write carries the rate, the supervision enable, the interrupt enable and an acknowledge for the interrupt flag. The service write carries one key bit. Two level inputs mark the low-power wait and stop modes. Leaving stop mode is seen as the falling edge of the stop input. After that edge, the whole timer stays frozen for a programmable settling delay.

All periods are powers of two of the bus clock: 2^(BASE_LOG2+rate) cycles per tick. The minimum supervision timeout is EXPIRE_TICKS tick periods.

Top module: `wdt_top`

## Requirements
- R1: After reset `rtiPulse`, `rtiIrq`, `resetReq` and `wdEnabled` are low. While supervision is disabled, no reset request is ever raised.
- R2: A control write with `ctlData[2]`=1 sets `wdEnabled`, and the supervision counter starts counting ticks.
- R3: Once `wdEnabled` is set, a control write with `ctlData[2]`=0 leaves it set, and timeouts still occur. Only the end of a reset request clears it.
- R4: `rtiPulse` is a one-cycle pulse. It repeats every 2^(BASE_LOG2+r) cycles, where r is the applied rate.
- R5: `ctlData[1:0]` holds the requested rate (0..3). A new request takes effect only at the next service write. Until then, the tick period is unchanged.
- R6: A service write with `svcKey`=0 clears the supervision count. A service write with `svcKey`=1 has no effect.
- R7: With supervision enabled, `resetReq` rises in the same cycle as the (EXPIRE_TICKS+1)-th counted pulse after the last service. This gives at least EXPIRE_TICKS full periods.
- R8: `resetReq` stays high for exactly HOLD_CYCLES cycles. When it falls, `wdEnabled` is clear.
- R9: Each tick sets a sticky flag. `rtiIrq` is the flag gated by `ctlData[3]`. A control write with `ctlData[4]`=1 clears the flag.
- R10: While `waitMode` is high, ticks continue but are not counted toward a timeout. Counting resumes at once when wait ends.
- R11: While `stopMode` is high, the prescaler and the count are frozen. After `stopMode` falls, they stay frozen for exactly STOP_DELAY more cycles. The first tick then follows STOP_DELAY plus the remaining prescaler cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low reset (power-on or external) |
| ctlWrite | input | 1 | Control register write strobe |
| ctlData | input | 5 | [1:0] rate, [2] supervision enable, [3] interrupt enable, [4] flag acknowledge |
| svcWrite | input | 1 | Service write strobe |
| svcKey | input | 1 | Service key bit; 0 clears the supervision count |
| waitMode | input | 1 | Wait mode level |
| stopMode | input | 1 | Stop mode level; its falling edge marks the wake from stop |
| rtiPulse | output | 1 | One-cycle periodic tick |
| rtiIrq | output | 1 | Periodic interrupt request |
| wdEnabled | output | 1 | Supervision enable state |
| resetReq | output | 1 | System reset request |

## Verification
The assertions assume at least two cycles between ticks, so BASE_LOG2 must be at least 1. They also assume that the mode inputs and write strobes change only between clock edges.

The stimulus drives every input at the falling edge. It issues each service right after an observed tick, so that a service never lands on a tick cycle. It changes the rate bits only ahead of a service, as the rate rule intends. Writes and services never share a cycle, because the order between them is not defined.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int RATE_W = 2;
  localparam int CTL_W  = 5;

  // Strobes from control to datapath
  typedef struct packed {
    logic preRun;   // prescaler advances this cycle
    logic wdRun;    // supervision counter may count ticks
    logic wdClear;  // clear the supervision counter
  } wdtStrobe_t;
endpackage

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter int BASE_LOG2    = 14,
  parameter int EXPIRE_TICKS = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  wdtStrobe_t        strobe,
  input  logic [RATE_W-1:0] rate,
  output logic              tick,
  output logic              tickQ,
  output logic              wdExpire
);
  localparam int PW = BASE_LOG2 + (1 << RATE_W) - 1;
  localparam int CW = $clog2(EXPIRE_TICKS + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(EXPIRE_TICKS);

  logic [PW-1:0] preCnt;
  logic [PW-1:0] mask;
  logic [CW-1:0] wdCnt;

  // Low (BASE_LOG2 + rate) bits select the tick
  assign mask = ~({PW{1'b1}} << (BASE_LOG2 + int'(rate)));
  assign tick = strobe.preRun && ((preCnt & mask) == mask);
  assign wdExpire = tick && strobe.wdRun && (wdCnt == CNT_MAX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
      tickQ  <= 1'b0;
    end else begin
      tickQ <= tick;
      if (strobe.preRun) preCnt <= preCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wdCnt <= '0;
    end else if (strobe.wdClear) begin
      wdCnt <= '0;
    end else if (tick && strobe.wdRun && (wdCnt != CNT_MAX)) begin
      wdCnt <= wdCnt + 1'b1;
    end
  end
endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
#(
  parameter int STOP_DELAY  = 4064,
  parameter int HOLD_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctlWrite,
  input  logic [CTL_W-1:0]  ctlData,
  input  logic              svcWrite,
  input  logic              svcKey,
  input  logic              waitMode,
  input  logic              stopMode,
  input  logic              tick,
  input  logic              wdExpire,
  output wdtStrobe_t        strobe,
  output logic [RATE_W-1:0] rate,
  output logic              rtiIrq,
  output logic              wdEnabled,
  output logic              resetReq
);
  localparam int DW = $clog2(STOP_DELAY + 1);
  localparam int HW = $clog2(HOLD_CYCLES + 1);
  localparam logic [DW-1:0] DELAY_LOAD = DW'(STOP_DELAY - 1);
  localparam logic [HW-1:0] HOLD_LOAD  = HW'(HOLD_CYCLES);

  logic [RATE_W-1:0] rateReq;
  logic [RATE_W-1:0] rateAct;
  logic              irqEn;
  logic              flag;
  logic              wdOn;
  logic              stopQ;
  logic [DW-1:0]     delayCnt;
  logic [HW-1:0]     holdCnt;
  logic              svcHit;
  logic              holdEnd;

  assign svcHit  = svcWrite && !svcKey;
  assign holdEnd = (holdCnt == HW'(1));

  always_comb begin
    strobe.preRun  = !stopMode && !stopQ && (delayCnt == '0);
    strobe.wdRun   = wdOn && !waitMode && !stopMode && (holdCnt == '0);
    strobe.wdClear = svcHit || holdEnd;
  end

  assign rate      = rateAct;
  assign rtiIrq    = flag && irqEn;
  assign wdEnabled = wdOn;
  assign resetReq  = (holdCnt != '0);

  // Register fields and the rate applied at service
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rateReq <= '0;
      rateAct <= '0;
      irqEn   <= 1'b0;
      flag    <= 1'b0;
    end else begin
      if (ctlWrite) begin
        rateReq <= ctlData[1:0];
        irqEn   <= ctlData[3];
      end
      if (svcHit) rateAct <= rateReq;
      if (tick) flag <= 1'b1;
      else if (ctlWrite && ctlData[4]) flag <= 1'b0;
    end
  end

  // Enable is set-only until the reset request ends
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wdOn    <= 1'b0;
      holdCnt <= '0;
    end else begin
      if (wdExpire) holdCnt <= HOLD_LOAD;
      else if (holdCnt != '0) holdCnt <= holdCnt - 1'b1;
      if (holdEnd) wdOn <= 1'b0;
      else if (ctlWrite && ctlData[2] && (holdCnt == '0)) wdOn <= 1'b1;
    end
  end

  // Settling delay after leaving stop
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stopQ    <= 1'b0;
      delayCnt <= '0;
    end else begin
      stopQ <= stopMode;
      if (stopQ && !stopMode) delayCnt <= DELAY_LOAD;
      else if (delayCnt != '0) delayCnt <= delayCnt - 1'b1;
    end
  end
endmodule

// File: rtl/wdt_top.sv
module wdt_top
  import wdt_pkg::*;
#(
  parameter int BASE_LOG2    = 14,
  parameter int EXPIRE_TICKS = 7,
  parameter int STOP_DELAY   = 4064,
  parameter int HOLD_CYCLES  = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ctlWrite,
  input  logic [CTL_W-1:0] ctlData,
  input  logic             svcWrite,
  input  logic             svcKey,
  input  logic             waitMode,
  input  logic             stopMode,
  output logic             rtiPulse,
  output logic             rtiIrq,
  output logic             wdEnabled,
  output logic             resetReq
);
  wdtStrobe_t        strobe;
  logic [RATE_W-1:0] rate;
  logic              tick;
  logic              wdExpire;

  wdt_ctrl #(.STOP_DELAY(STOP_DELAY), .HOLD_CYCLES(HOLD_CYCLES)) uCtrl (
    .clk(clk), .rstN(rstN), .ctlWrite(ctlWrite), .ctlData(ctlData),
    .svcWrite(svcWrite), .svcKey(svcKey), .waitMode(waitMode),
    .stopMode(stopMode), .tick(tick), .wdExpire(wdExpire),
    .strobe(strobe), .rate(rate), .rtiIrq(rtiIrq),
    .wdEnabled(wdEnabled), .resetReq(resetReq)
  );

  wdt_datapath #(.BASE_LOG2(BASE_LOG2), .EXPIRE_TICKS(EXPIRE_TICKS)) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rate(rate),
    .tick(tick), .tickQ(rtiPulse), .wdExpire(wdExpire)
  );
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
  parameter int HOLD = 16
) (
  input logic clk,
  input logic rstN,
  input logic ctlWrite,
  input logic waitMode,
  input logic stopMode,
  input logic rtiPulse,
  input logic rtiIrq,
  input logic wdEnabled,
  input logic resetReq
);
  int holdRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) holdRun <= 0;
    else if (resetReq) holdRun <= holdRun + 1;
    else holdRun <= 0;
  end

  assert_enable_sticky_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wdEnabled && !resetReq) |=> wdEnabled);

  assert_reset_needs_enable_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(resetReq) |-> wdEnabled);

  assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    rtiPulse |=> !rtiPulse);

  assert_hold_length_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(resetReq) |-> (holdRun == HOLD));

  assert_irq_source_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rtiIrq) |-> (rtiPulse || $past(ctlWrite)));

  assert_wait_no_expire_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(resetReq) |-> !$past(waitMode));

  assert_stop_freeze_R11: assert property (@(posedge clk) disable iff (!rstN)
    stopMode |=> !rtiPulse);
endmodule

bind wdt_top wdt_checker #(.HOLD(HOLD_CYCLES)) uChk (
  .clk(clk), .rstN(rstN), .ctlWrite(ctlWrite), .waitMode(waitMode),
  .stopMode(stopMode), .rtiPulse(rtiPulse), .rtiIrq(rtiIrq),
  .wdEnabled(wdEnabled), .resetReq(resetReq)
);

// File: tb/tb_wdt_top.sv
module tb_wdt_top;
  localparam int B   = 3;
  localparam int EXP = 7;
  localparam int SD  = 20;
  localparam int HC  = 4;
  localparam int P0  = 1 << B;

  typedef struct {
    int    interval;
    string tag;
  } expItem_t;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       ctlWrite = 1'b0;
  logic [4:0] ctlData = '0;
  logic       svcWrite = 1'b0;
  logic       svcKey = 1'b1;
  logic       waitMode = 1'b0;
  logic       stopMode = 1'b0;
  logic       rtiPulse, rtiIrq, wdEnabled, resetReq;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int negCount = 0;
  int lastPulse = 0;
  bit havePulse = 0;
  int resetRises = 0;
  bit prevReset = 0;
  expItem_t expQ[$];
  event pulseEv;

  always #2 clk = ~clk;

  wdt_top #(.BASE_LOG2(B), .EXPIRE_TICKS(EXP), .STOP_DELAY(SD), .HOLD_CYCLES(HC)) dut (
    .clk(clk), .rstN(rstN), .ctlWrite(ctlWrite), .ctlData(ctlData),
    .svcWrite(svcWrite), .svcKey(svcKey), .waitMode(waitMode),
    .stopMode(stopMode), .rtiPulse(rtiPulse), .rtiIrq(rtiIrq),
    .wdEnabled(wdEnabled), .resetReq(resetReq)
  );

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 100000);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  // Monitor: compares tick intervals against the expected queue
  always @(negedge clk) begin
    negCount++;
    if (rstN && resetReq && !prevReset) resetRises++;
    prevReset = resetReq;
    if (rstN && rtiPulse) begin
      if (havePulse && expQ.size() > 0) begin
        expItem_t e;
        e = expQ.pop_front();
        check(negCount - lastPulse == e.interval, e.tag, negCount - lastPulse, e.interval);
      end
      lastPulse = negCount;
      havePulse = 1;
      ->pulseEv;
    end
  end

  task automatic ctlWr(input logic [4:0] d);
    ctlWrite = 1'b1; ctlData = d;
    @(negedge clk);
    ctlWrite = 1'b0;
  endtask

  task automatic svc(input logic key);
    svcWrite = 1'b1; svcKey = key;
    @(negedge clk);
    svcWrite = 1'b0; svcKey = 1'b1;
  endtask

  task automatic expectPeriods(input int n, input int per, input string tag);
    @(pulseEv);
    for (int i = 0; i < n; i++) expQ.push_back('{per, tag});
    while (expQ.size() != 0) @(negedge clk);
  endtask

  task automatic pulsesToReset(output int n);
    n = 0;
    for (int i = 0; i < 3000 && !resetReq; i++) begin
      @(negedge clk);
      if (rtiPulse) n++;
    end
  endtask

  task automatic checkHold(input string tag);
    int len = 0;
    while (resetReq && len < 100) begin
      len++;
      @(negedge clk);
    end
    check(len == HC, {tag, " R8 hold length"}, len, HC);
    check(wdEnabled == 1'b0, {tag, " R8 enable cleared"}, wdEnabled, 0);
  endtask

  initial begin
    int n;
    int r0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check({rtiPulse, rtiIrq, wdEnabled, resetReq} == 4'b0, "R1 reset outputs",
          {rtiPulse, rtiIrq, wdEnabled, resetReq}, 0);

    // R4 base period at rate 0
    expectPeriods(3, P0, "R4 rate0 period");

    // R9 sticky flag, gating and acknowledge
    @(pulseEv);
    check(rtiIrq == 1'b0, "R9 irq gated off", rtiIrq, 0);
    ctlWr(5'b01000);
    check(rtiIrq == 1'b1, "R9 flag sticky", rtiIrq, 1);
    ctlWr(5'b11000);
    check(rtiIrq == 1'b0, "R9 acknowledge clears", rtiIrq, 0);
    @(pulseEv);
    check(rtiIrq == 1'b1, "R9 flag set by tick", rtiIrq, 1);
    ctlWr(5'b10000);

    // R1 disabled supervision never resets
    r0 = resetRises;
    repeat (120) @(negedge clk);
    check(resetRises == r0 && !wdEnabled, "R1 no reset while disabled", resetRises - r0, 0);

    // R2 / R7 enable and timeout
    ctlWr(5'b00100);
    check(wdEnabled == 1'b1, "R2 enable set", wdEnabled, 1);
    @(pulseEv);
    svc(1'b0);
    pulsesToReset(n);
    check(n == EXP + 1, "R7 pulses to timeout", n, EXP + 1);
    checkHold("first");

    // R10 wait freezes counting, RTI continues
    ctlWr(5'b00100);
    @(pulseEv);
    waitMode = 1'b1;
    svc(1'b0);
    r0 = resetRises;
    n = 0;
    for (int i = 0; i < 150; i++) begin
      @(negedge clk);
      if (rtiPulse) n++;
    end
    check(n > 10, "R10 ticks continue in wait", n, 18);
    check(resetRises == r0, "R10 no timeout in wait", resetRises - r0, 0);
    @(pulseEv);
    waitMode = 1'b0;
    pulsesToReset(n);
    check(n == EXP + 1, "R10 counting resumes after wait", n, EXP + 1);
    checkHold("wait");

    // R6 service keeps it alive, key 1 ignored
    ctlWr(5'b00100);
    @(pulseEv);
    svc(1'b0);
    r0 = resetRises;
    for (int k = 0; k < 6; k++) begin
      repeat (5) @(pulseEv);
      svc(1'b0);
    end
    check(resetRises == r0, "R6 regular service prevents reset", resetRises - r0, 0);
    repeat (3) @(pulseEv);
    svc(1'b1);
    pulsesToReset(n);
    check(n == EXP + 1 - 3, "R6 key 1 has no effect", n, EXP + 1 - 3);
    checkHold("svc");

    // R3 cannot disable; R11 stop freeze and settling delay
    ctlWr(5'b00100);
    ctlWr(5'b00000);
    check(wdEnabled == 1'b1, "R3 disable write ignored", wdEnabled, 1);
    @(pulseEv);
    stopMode = 1'b1;
    svc(1'b0);
    r0 = resetRises;
    n = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (rtiPulse) n++;
    end
    check(n == 0, "R11 no ticks in stop", n, 0);
    stopMode = 1'b0;
    n = 0;
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      n++;
      if (rtiPulse) break;
    end
    check(n == SD + P0, "R11 first tick after stop delay", n, SD + P0);
    check(resetRises == r0, "R11 no timeout across stop", resetRises - r0, 0);
    pulsesToReset(n);
    check(n == EXP, "R3 timeout after disable attempt", n, EXP);
    checkHold("stop");

    // R5 rate applies only at service
    ctlWr(5'b00010);
    expectPeriods(3, P0, "R5 rate held until service");
    @(pulseEv);
    svc(1'b0);
    expectPeriods(3, P0 * 4, "R5 rate2 after service");
    ctlWr(5'b00011);
    @(pulseEv);
    svc(1'b0);
    expectPeriods(2, P0 * 8, "R4 rate3 period");

    // R7 timeout scales with rate
    ctlWr(5'b00101);
    @(pulseEv);
    svc(1'b0);
    pulsesToReset(n);
    check(n == EXP + 1, "R7 timeout at rate1", n, EXP + 1);
    checkHold("rate1");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule